// File: doc/BRIEF.md
# BCD Calendar Clock Register File

This block is a real-time clock and calendar that sits in the top sixteen byte addresses of a byte-wide memory space. It holds century, year, month, date, day of week, hours, minutes and seconds as packed BCD in 24-hour form. It advances once per second, and the second is derived from a stream of single-cycle `subTick` pulses.

There are two copies of the time. An internal copy does the counting and never stops. A visible copy is what the CPU reads and writes with chip-enable, output-enable and write-enable strobes. The visible copy follows the internal one on every clock. Software can set a hold bit in the control byte so that the visible copy stays still while it reads several fields. The internal count keeps going while the hold bit is set. Clearing the bit reloads the visible copy. A battery-low input appears as a read-only flag bit.

Top module: `bcd_rtc_regs`

## Requirements
- R1: The block decodes only the sixteen addresses whose upper address bits are all ones. Offset 0x0 is the flag byte, offset 0x7 is the century, offset 0x8 is the control byte, and offsets 0x9 to 0xF are seconds, minutes, hours, day of week, date, month and year. Writes outside this window change nothing, and reads outside it return 0x00.
- R2: Each field is stored as packed BCD in 24-hour form. A write is masked to the field's width: seconds and minutes 7 bits, hours 6 bits, day of week 3 bits, date 6 bits, month 5 bits, year and century 8 bits.
- R3: When seconds pass 59 they return to 00 and minutes advance. Minutes 59 to 00 advance hours. Hours 23 to 00 advance both the date and the day of week. Day of week wraps from 7 to 1.
- R4: The date rolls to 01 after the last day of the month: 31 for months 01, 03, 05, 07, 08, 10 and 12, 30 for months 04, 06, 09 and 11, and 28 or 29 for month 02. Month 12 rolls to 01 and advances the year.
- R5: A year whose two-digit BCD value is divisible by 4 is a leap year, and year 00 counts as one. February then has 29 days.
- R6: Year 99 rolling to 00 advances the BCD century, and century 99 wraps to 00.
- R7: One second is TICKS_PER_SEC pulses of `subTick`. A write to any time field restarts this count, so the next second falls a full TICKS_PER_SEC pulses after the write.
- R8: A write to a time field loads the same value into both the internal and the visible copy, including while the hold bit is set.
- R9: Bit 6 of the control byte is the hold bit and reads back as written; the other control bits read 0. While the hold bit is 1 the visible copy does not change except through writes, and the internal copy keeps counting. One clock after the bit is cleared, the visible copy equals the internal copy.
- R10: Bit 4 of the flag byte reads the `battLow` input, and the other flag bits read 0. Writes to the flag byte have no effect.
- R11: `rdOe` is 1 only when `ceN` is 0, `weN` is 1 and `oeN` is 0. While `ceN` is 0 and `weN` is 1, `rdData` carries the addressed byte.
- R12: A write starts in the first clock in which both `ceN` and `weN` are 0, whichever of the two fell later. The data is taken in that clock only, and a held-low period makes exactly one write.
- R13: After reset the time is century 20, year 00, month 01, date 01, day of week 1, 00:00:00, and the hold bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| subTick | input | 1 | Single-cycle pulse; TICKS_PER_SEC pulses make one second |
| battLow | input | 1 | Battery-low indication, reflected in the flag byte |
| ceN | input | 1 | Chip enable, active low |
| oeN | input | 1 | Output enable, active low |
| weN | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Byte address |
| wrData | input | 8 | Write data byte |
| rdData | output | 8 | Read data byte |
| rdOe | output | 1 | High when read data should drive the bus |

## Verification
The counting logic is exercised with a table of starting times. Each entry is loaded through the bus and checked after exactly one second. The entries cover:
- a plain seconds step;
- a minute carry and a full day carry;
- 30-day and 31-day month ends;
- February in a common year, in a leap year with an odd tens digit, in a leap year with an even tens digit, and in year 00;
- a BCD month carry from 09 to 10;
- the year carry into the century, and the century wrap.

Each entry targets one branch of the month-length and leap decision, so a fault in one branch fails only that entry.

Directed sequences check the other behaviour:
- the prescaler restart is probed one pulse short of the second;
- the hold bit is probed across two elapsed seconds;
- the late-chip-enable write is probed by changing the data while the strobes stay low;
- the flag bit is probed while a write to the flag byte is attempted.

// File: rtl/bcd_rtc_pkg.sv
package bcd_rtc_pkg;
  localparam int FIELD_CNT = 8;

  typedef logic [FIELD_CNT-1:0][7:0] calSet_t;

  typedef enum logic [2:0] {
    F_SEC, F_MIN, F_HOUR, F_WDAY, F_DATE, F_MONTH, F_YEAR, F_CENT
  } fieldId_e;

  typedef struct packed {
    logic     secTick;
    logic     fieldWr;
    fieldId_e fieldSel;
    logic [7:0] wrByte;
    logic     holdExt;
  } ctlStrb_t;

  localparam calSet_t RESET_TIME = 64'h20_00_01_01_01_00_00_00;

  function automatic logic [7:0] fieldMask(fieldId_e f);
    case (f)
      F_SEC, F_MIN:    return 8'h7F;
      F_HOUR, F_DATE:  return 8'h3F;
      F_WDAY:          return 8'h07;
      F_MONTH:         return 8'h1F;
      default:         return 8'hFF;
    endcase
  endfunction

  function automatic logic [7:0] bcdInc(logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // divisible by 4 in BCD: even tens -> units 0/4/8, odd tens -> units 2/6
  function automatic logic isLeap(logic [7:0] yr);
    if (yr[4]) return (yr[3:0] == 4'd2) || (yr[3:0] == 4'd6);
    return (yr[3:0] == 4'd0) || (yr[3:0] == 4'd4) || (yr[3:0] == 4'd8);
  endfunction

  function automatic logic [7:0] monthLen(logic [7:0] mon, logic [7:0] yr);
    case (mon)
      8'h02:                      return isLeap(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/bcd_rtc_ctl.sv
module bcd_rtc_ctl
  import bcd_rtc_pkg::*;
#(
  parameter int ADDR_W        = 15,
  parameter int TICKS_PER_SEC = 4096
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              subTick,
  input  logic              ceN,
  input  logic              weN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  output ctlStrb_t          strb
);
  localparam int PRE_W = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICKS_PER_SEC - 1);

  logic [PRE_W-1:0] presc;
  logic             wrPrev;
  logic             freeze;
  logic             inWindow;
  logic [3:0]       off;
  logic [3:0]       selTmp;
  logic             wrStart;
  logic             isField;
  logic             isCtl;

  assign off      = addr[3:0];
  assign inWindow = &addr[ADDR_W-1:4];
  assign isField  = inWindow && (off == 4'h7 || off >= 4'h9);
  assign isCtl    = inWindow && (off == 4'h8);
  assign wrStart  = !ceN && !weN && !wrPrev;
  assign selTmp   = off - 4'h9;

  always_comb begin
    strb.fieldWr  = wrStart && isField;
    strb.fieldSel = (off == 4'h7) ? F_CENT : fieldId_e'(selTmp[2:0]);
    strb.wrByte   = wrData;
    strb.secTick  = subTick && (presc == PRE_LAST) && !strb.fieldWr;
    strb.holdExt  = freeze;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      presc  <= '0;
      wrPrev <= 1'b0;
      freeze <= 1'b0;
    end else begin
      wrPrev <= !ceN && !weN;
      if (strb.fieldWr)
        presc <= '0;
      else if (subTick)
        presc <= (presc == PRE_LAST) ? '0 : presc + 1'b1;
      if (wrStart && isCtl)
        freeze <= wrData[6];
    end
  end
endmodule

// File: rtl/bcd_rtc_dp.sv
module bcd_rtc_dp
  import bcd_rtc_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrb_t          strb,
  input  logic              battLow,
  input  logic              ceN,
  input  logic              weN,
  input  logic              oeN,
  input  logic [ADDR_W-1:0] addr,
  output logic [7:0]        rdData,
  output logic              rdOe,
  output calSet_t           intTime,
  output calSet_t           extTime
);
  calSet_t    nxt;
  logic       cMin, cHour, cDay, cMon, cYear, cCent;
  logic [7:0] wrMasked;
  logic [3:0] off;
  logic [3:0] idxTmp;
  logic       inWindow;
  logic       rdSel;

  assign wrMasked = strb.wrByte & fieldMask(strb.fieldSel);

  // carry chain for one elapsed second
  always_comb begin
    nxt = intTime;
    cMin = intTime[F_SEC] == 8'h59;
    nxt[F_SEC] = cMin ? 8'h00 : bcdInc(intTime[F_SEC]);
    cHour = cMin && intTime[F_MIN] == 8'h59;
    if (cMin) nxt[F_MIN] = (intTime[F_MIN] == 8'h59) ? 8'h00 : bcdInc(intTime[F_MIN]);
    cDay = cHour && intTime[F_HOUR] == 8'h23;
    if (cHour) nxt[F_HOUR] = (intTime[F_HOUR] == 8'h23) ? 8'h00 : bcdInc(intTime[F_HOUR]);
    if (cDay) nxt[F_WDAY] = (intTime[F_WDAY] >= 8'h07) ? 8'h01 : intTime[F_WDAY] + 8'h01;
    cMon = cDay && intTime[F_DATE] == monthLen(intTime[F_MONTH], intTime[F_YEAR]);
    if (cDay) nxt[F_DATE] = cMon ? 8'h01 : bcdInc(intTime[F_DATE]);
    cYear = cMon && intTime[F_MONTH] == 8'h12;
    if (cMon) nxt[F_MONTH] = cYear ? 8'h01 : bcdInc(intTime[F_MONTH]);
    cCent = cYear && intTime[F_YEAR] == 8'h99;
    if (cYear) nxt[F_YEAR] = cCent ? 8'h00 : bcdInc(intTime[F_YEAR]);
    if (cCent) nxt[F_CENT] = (intTime[F_CENT] == 8'h99) ? 8'h00 : bcdInc(intTime[F_CENT]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intTime <= RESET_TIME;
      extTime <= RESET_TIME;
    end else begin
      if (strb.fieldWr)
        intTime[strb.fieldSel] <= wrMasked;
      else if (strb.secTick)
        intTime <= nxt;
      if (strb.fieldWr)
        extTime[strb.fieldSel] <= wrMasked;
      else if (!strb.holdExt)
        extTime <= intTime;
    end
  end

  assign off      = addr[3:0];
  assign idxTmp   = off - 4'h9;
  assign inWindow = &addr[ADDR_W-1:4];
  assign rdSel    = !ceN && weN;
  assign rdOe     = rdSel && !oeN;

  always_comb begin
    rdData = 8'h00;
    if (rdSel && inWindow) begin
      if (off == 4'h0)      rdData = {3'b000, battLow, 4'b0000};
      else if (off == 4'h7) rdData = extTime[F_CENT];
      else if (off == 4'h8) rdData = {1'b0, strb.holdExt, 6'b000000};
      else if (off >= 4'h9) rdData = extTime[idxTmp[2:0]];
    end
  end
endmodule

// File: rtl/bcd_rtc_regs.sv
module bcd_rtc_regs
  import bcd_rtc_pkg::*;
#(
  parameter int ADDR_W        = 15,
  parameter int TICKS_PER_SEC = 4096
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              subTick,
  input  logic              battLow,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              weN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  output logic [7:0]        rdData,
  output logic              rdOe
);
  ctlStrb_t ctlStrb;
  calSet_t  intTime;
  calSet_t  extTime;

  bcd_rtc_ctl #(.ADDR_W(ADDR_W), .TICKS_PER_SEC(TICKS_PER_SEC)) u_ctl (
    .clk(clk), .rstN(rstN), .subTick(subTick), .ceN(ceN), .weN(weN),
    .addr(addr), .wrData(wrData), .strb(ctlStrb)
  );

  bcd_rtc_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(ctlStrb), .battLow(battLow), .ceN(ceN),
    .weN(weN), .oeN(oeN), .addr(addr), .rdData(rdData), .rdOe(rdOe),
    .intTime(intTime), .extTime(extTime)
  );
endmodule

// File: rtl/bcd_rtc_regs_chk.sv
module bcd_rtc_regs_chk
  import bcd_rtc_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input logic              clk,
  input logic              rstN,
  input logic              ceN,
  input logic              weN,
  input logic              battLow,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        rdData,
  input ctlStrb_t          ctlStrb,
  input calSet_t           intTime,
  input calSet_t           extTime
);
  // R2
  sec_bcd_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctlStrb.secTick && intTime[0][3:0] <= 4'd9 && intTime[0][7:4] <= 4'd5)
    |=> (intTime[0][3:0] <= 4'd9 && intTime[0][7:4] <= 4'd5));

  // R3
  tick_moves_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctlStrb.secTick |=> intTime[0] != $past(intTime[0]));

  // R8
  wr_both_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctlStrb.fieldWr |=> intTime[$past(ctlStrb.fieldSel)] == extTime[$past(ctlStrb.fieldSel)]);

  // R9
  frozen_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctlStrb.holdExt && !ctlStrb.fieldWr) |=> $stable(extTime));

  // R10
  batt_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ceN && weN && (&addr[ADDR_W-1:4]) && addr[3:0] == 4'h0) |-> rdData[4] == battLow);
endmodule

bind bcd_rtc_regs bcd_rtc_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .battLow(battLow),
  .addr(addr), .rdData(rdData), .ctlStrb(ctlStrb), .intTime(intTime),
  .extTime(extTime)
);

// File: tb/bcd_rtc_regs_bench.sv
module bcd_rtc_regs_bench;
  localparam int TPS = 4;
  localparam int NVEC = 13;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic subTick = 1'b0;
  logic battLow = 1'b0;
  logic ceN = 1'b1, oeN = 1'b1, weN = 1'b1;
  logic [14:0] addr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic rdOe;

  int nChk = 0;
  int nFail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  bcd_rtc_regs #(.ADDR_W(15), .TICKS_PER_SEC(TPS)) u_bcd_rtc_regs (
    .clk(clk), .rstN(rstN), .subTick(subTick), .battLow(battLow), .ceN(ceN),
    .oeN(oeN), .weN(weN), .addr(addr), .wrData(wrData), .rdData(rdData), .rdOe(rdOe)
  );

  // byte i: 0 sec,1 min,2 hour,3 wday,4 date,5 month,6 year,7 century
  localparam logic [63:0] VEC_IN [NVEC] = '{
    64'h20_24_03_15_03_12_34_56, 64'h20_24_03_15_03_10_59_59,
    64'h20_23_04_30_07_23_59_59, 64'h20_23_02_28_02_23_59_59,
    64'h20_24_02_28_03_23_59_59, 64'h20_24_02_29_04_23_59_59,
    64'h19_99_12_31_05_23_59_59, 64'h21_00_02_28_01_23_59_59,
    64'h20_25_01_31_06_23_59_59, 64'h20_25_09_30_02_23_59_59,
    64'h99_99_12_31_04_23_59_59, 64'h20_12_02_28_02_23_59_59,
    64'h20_18_02_28_03_23_59_59 };
  localparam logic [63:0] VEC_EXP [NVEC] = '{
    64'h20_24_03_15_03_12_34_57, 64'h20_24_03_15_03_11_00_00,
    64'h20_23_05_01_01_00_00_00, 64'h20_23_03_01_03_00_00_00,
    64'h20_24_02_29_04_00_00_00, 64'h20_24_03_01_05_00_00_00,
    64'h20_00_01_01_06_00_00_00, 64'h21_00_02_29_02_00_00_00,
    64'h20_25_02_01_07_00_00_00, 64'h20_25_10_01_03_00_00_00,
    64'h00_00_01_01_05_00_00_00, 64'h20_12_02_29_03_00_00_00,
    64'h20_18_03_01_04_00_00_00 };
  localparam string VEC_REQ [NVEC] = '{
    "R3", "R3", "R4", "R4", "R5", "R4", "R6", "R5", "R4", "R4", "R6", "R5", "R5" };

  function automatic logic [14:0] fieldAddr(int i);
    return (i == 7) ? 15'h7FF7 : 15'(32'h7FF9 + i);
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [14:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wrData = d; oeN = 1'b1; ceN = 1'b0; weN = 1'b0;
    @(negedge clk); ceN = 1'b1; weN = 1'b1;
  endtask

  task automatic busRead(input logic [14:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; weN = 1'b1; ceN = 1'b0; oeN = 1'b0;
    #1 d = rdData;
    @(negedge clk); ceN = 1'b1; oeN = 1'b1;
  endtask

  task automatic writeAll(input logic [63:0] t);
    for (int i = 0; i < 8; i++) busWrite(fieldAddr(i), t[i*8 +: 8]);
  endtask

  task automatic readAll(output logic [63:0] t);
    logic [7:0] b;
    for (int i = 0; i < 8; i++) begin
      busRead(fieldAddr(i), b);
      t[i*8 +: 8] = b;
    end
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); subTick = 1'b1;
      @(negedge clk); subTick = 1'b0;
    end
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
      $finish;
    end
  end

  initial begin
    logic [63:0] t;
    logic [7:0] b;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R13 reset state
    readAll(t);
    check("R13 reset time", t, 64'h20_00_01_01_01_00_00_00);
    busRead(15'h7FF8, b);
    check("R13 hold bit clear", {56'd0, b}, 64'h00);

    // rollover table: R3 R4 R5 R6 across one second
    for (int v = 0; v < NVEC; v++) begin
      writeAll(VEC_IN[v]);
      pulses(TPS);
      readAll(t);
      check(VEC_REQ[v], t, VEC_EXP[v]);
    end

    // R7 prescaler restart on write
    pulses(TPS - 1);
    busWrite(15'h7FF9, 8'h10);
    pulses(TPS - 1);
    busRead(15'h7FF9, b);
    check("R7 no second before full count", {56'd0, b}, 64'h10);
    pulses(1);
    busRead(15'h7FF9, b);
    check("R7 second after full count", {56'd0, b}, 64'h11);

    // R2 write masking
    busWrite(15'h7FF9, 8'hD5);
    busRead(15'h7FF9, b);
    check("R2 seconds masked", {56'd0, b}, 64'h55);
    busWrite(15'h7FFC, 8'hF3);
    busRead(15'h7FFC, b);
    check("R2 weekday masked", {56'd0, b}, 64'h03);

    // R9 hold bit, R8 write while held
    writeAll(64'h20_24_06_10_01_12_00_00);
    busWrite(15'h7FF8, 8'h40);
    busRead(15'h7FF8, b);
    check("R9 hold bit readback", {56'd0, b}, 64'h40);
    pulses(2 * TPS);
    busRead(15'h7FF9, b);
    check("R9 visible copy frozen", {56'd0, b}, 64'h00);
    busWrite(15'h7FFA, 8'h45);
    busRead(15'h7FFA, b);
    check("R8 write visible while held", {56'd0, b}, 64'h45);
    busWrite(15'h7FF8, 8'h00);
    busRead(15'h7FF9, b);
    check("R9 reload after release", {56'd0, b}, 64'h02);
    busRead(15'h7FFA, b);
    check("R8 internal took write", {56'd0, b}, 64'h45);

    // R10 battery flag
    battLow = 1'b1;
    busRead(15'h7FF0, b);
    check("R10 flag set", {56'd0, b}, 64'h10);
    busWrite(15'h7FF0, 8'h00);
    busRead(15'h7FF0, b);
    check("R10 flag unaffected by write", {56'd0, b}, 64'h10);
    battLow = 1'b0;
    busRead(15'h7FF0, b);
    check("R10 flag clear", {56'd0, b}, 64'h00);

    // R11 output enable
    @(negedge clk); addr = 15'h7FF9; weN = 1'b1; ceN = 1'b0; oeN = 1'b1;
    #1 check("R11 rdOe low with oeN high", {63'd0, rdOe}, 64'd0);
    oeN = 1'b0;
    #1 check("R11 rdOe high on read", {63'd0, rdOe}, 64'd1);
    weN = 1'b0;
    #1 check("R11 rdOe low during write", {63'd0, rdOe}, 64'd0);
    @(negedge clk); weN = 1'b1; ceN = 1'b1; oeN = 1'b1;

    // R12 write starts at later strobe, data taken once
    @(negedge clk); addr = 15'h7FF9; wrData = 8'h33; weN = 1'b0; ceN = 1'b1;
    @(negedge clk); ceN = 1'b0;
    @(negedge clk); wrData = 8'h44;
    @(negedge clk); ceN = 1'b1; weN = 1'b1;
    busRead(15'h7FF9, b);
    check("R12 data from first clock of write", {56'd0, b}, 64'h33);

    // R1 outside window
    busWrite(15'h0009, 8'h22);
    busRead(15'h7FF9, b);
    check("R1 write outside window ignored", {56'd0, b}, 64'h33);
    busRead(15'h0009, b);
    check("R1 read outside window", {56'd0, b}, 64'h00);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end
endmodule